// File: doc/BRIEF.md
# Wrapping Page Write Buffer

This block sits between a serial memory's bus front end and its storage array. A write sequence opens with a 14-bit start address. The upper bits select a page, and that page stays fixed for the whole sequence. The lower six bits give a starting offset inside that page. Each byte-load strobe stores one byte at the current offset and moves the offset forward by one. Past the last byte of the page the offset returns to the first byte, so a long burst overwrites what it stored earlier.

When the front end reports a valid end of transaction, the block starts one timed internal write cycle. During that cycle it replays the loaded locations to a byte-wide synchronous write port, one per clock, in ascending offset order. Locations that were never loaded in the current sequence are not written. A busy flag covers the whole programmable cycle, and the block ignores commands while busy is high. An abort ends the sequence without writing anything.

Command priority when idle is abort, then open, then commit, then load.

Top module: `page_stage_commit`

## Requirements
- R1: During and right after reset, `busy_o` and `mem_we_o` are low.
- R2: An accepted open latches `start_addr_i[13:6]` as the page and `start_addr_i[5:0]` as the first offset. Every write of the following commit carries that page in `mem_addr_o[13:6]`.
- R3: Each accepted load stores its byte at the current offset, then advances the offset by one. Offset 63 is followed by offset 0 of the same page.
- R4: When a sequence loads one offset more than once, the commit writes the value from the last load.
- R5: After an accepted commit, busy-cycle k (k = 0 for the first cycle after the commit edge) carries the write for offset k, if that offset was loaded. No write appears for an offset that was not loaded.
- R6: An accepted commit raises `busy_o` in the following cycle. It stays high for exactly WR_CYCLES cycles (at least 64), then falls.
- R7: An open clears every loaded mark, so bytes from an earlier sequence are never written.
- R8: An abort while idle clears the loaded marks and closes the sequence. No busy cycle and no write follow from it.
- R9: Open, load and commit strobes while `busy_o` is high are ignored and change neither the commit in progress nor any later one.
- R10: A commit in a sequence with no loaded byte, or with no open sequence, starts no busy cycle.
- R11: `mem_we_o` is only high while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Open a new write sequence at `start_addr_i` |
| start_addr_i | input | 14 | Start address: page in [13:6], offset in [5:0] |
| load_i | input | 1 | Store `load_data_i` at the current offset |
| load_data_i | input | 8 | Byte to stage |
| stop_i | input | 1 | Transaction ended validly; commit the staged bytes |
| abort_i | input | 1 | Transaction ended invalidly; discard the staged bytes |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 14 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
Strobes are sampled at a rising edge. The write for offset k appears in the k-th cycle after the commit edge, and busy rises one cycle after that edge and falls WR_CYCLES cycles later. The bench applies inputs two time units after a rising edge and samples at the falling edge. A monitor counts busy cycles from the rise, and at each write it checks that the count equals the offset in the address. Before each write it pops the expected address and data from a queue that the driver filled from its own model. After each commit it waits out the full cycle and then checks that the queue is empty and that busy rose exactly as often as the model predicts.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int PSC_ADDR_W = 14;
    localparam int PSC_OFF_W  = 6;
    localparam int PSC_DATA_W = 8;

    // Action taken by the control path in one cycle
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_DROP,
        ACT_OPEN,
        ACT_COMMIT,
        ACT_CLOSE,
        ACT_LOAD
    } act_e;

    // Priority: busy blocks all, then abort, open, end, load
    function automatic act_e psc_decide(
        input logic busy,
        input logic active,
        input logic any_marked,
        input logic abort_req,
        input logic open_req,
        input logic end_req,
        input logic load_req
    );
        act_e a;
        a = ACT_NONE;
        if (busy) begin
            a = ACT_NONE;
        end else if (abort_req) begin
            a = ACT_DROP;
        end else if (open_req) begin
            a = ACT_OPEN;
        end else if (end_req && active) begin
            a = any_marked ? ACT_COMMIT : ACT_CLOSE;
        end else if (load_req && active) begin
            a = ACT_LOAD;
        end
        return a;
    endfunction

endpackage

// File: rtl/psc_cursor.sv
module psc_cursor #(
    parameter int ADDR_W = 14,
    parameter int OFF_W  = 6,
    localparam int PAGE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_en,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] open_addr,
    output logic [PAGE_W-1:0] page,
    output logic [OFF_W-1:0]  off
);
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (open_en) begin
            page_q <= open_addr[ADDR_W-1:OFF_W];
            off_q  <= open_addr[OFF_W-1:0];
        end else if (step_en) begin
            // natural rollover keeps the offset inside the page
            off_q <= off_q + 1'b1;
        end
    end

    assign page = page_q;
    assign off  = off_q;
endmodule

// File: rtl/psc_stage_buf.sv
module psc_stage_buf #(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_marked,
    output logic              any_marked
);
    logic [DEPTH-1:0]  mark_vec;
    logic [DATA_W-1:0] byte_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic              hit;
        logic              mark_q;
        logic [DATA_W-1:0] byte_q;

        assign hit = wr_en && (wr_off == OFF_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                mark_q <= 1'b0;
            end else if (hit) begin
                mark_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                byte_q <= wr_data;
            end
        end

        assign mark_vec[g] = mark_q;
        assign byte_arr[g] = byte_q;
    end

    assign rd_data    = byte_arr[rd_off];
    assign rd_marked  = mark_vec[rd_off];
    assign any_marked = |mark_vec;
endmodule

// File: rtl/psc_commit_seq.sv
module psc_commit_seq #(
    parameter int OFF_W     = 6,
    parameter int WR_CYCLES = 500000,
    localparam int SLOTS    = 1 << OFF_W,
    localparam int SPAN     = (WR_CYCLES < SLOTS) ? SLOTS : WR_CYCLES,
    localparam int CNT_W    = $clog2(SPAN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             busy,
    output logic             scan_on,
    output logic [OFF_W-1:0] scan_idx,
    output logic             done
);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SPAN - 1);
    localparam logic [CNT_W-1:0] SLOTS_CNT = CNT_W'(SLOTS);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    assign done = busy_q && (cnt_q == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (done) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy     = busy_q;
    assign scan_on  = busy_q && (cnt_q < SLOTS_CNT);
    assign scan_idx = cnt_q[OFF_W-1:0];
endmodule

// File: rtl/page_stage_commit.sv
module page_stage_commit
    import psc_pkg::*;
#(
    parameter int ADDR_W    = PSC_ADDR_W,
    parameter int OFF_W     = PSC_OFF_W,
    parameter int DATA_W    = PSC_DATA_W,
    parameter int WR_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              stop_i,
    input  logic              abort_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    act_e              act;
    logic              active_q;
    logic              busy;
    logic              any_marked;
    logic              rd_marked;
    logic [DATA_W-1:0] rd_data;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
    logic              scan_on;
    logic [OFF_W-1:0]  scan_idx;
    logic              done;

    always_comb begin
        act = psc_decide(busy, active_q, any_marked,
                         abort_i, start_i, stop_i, load_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_OPEN:                        active_q <= 1'b1;
                ACT_DROP, ACT_COMMIT, ACT_CLOSE: active_q <= 1'b0;
                default:                         active_q <= active_q;
            endcase
        end
    end

    psc_cursor #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) i_cursor (
        .clk       (clk),
        .rst       (rst),
        .open_en   (act == ACT_OPEN),
        .step_en   (act == ACT_LOAD),
        .open_addr (start_addr_i),
        .page      (page),
        .off       (off)
    );

    psc_stage_buf #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) i_stage (
        .clk        (clk),
        .rst        (rst),
        .clr        ((act == ACT_DROP) || (act == ACT_OPEN) || done),
        .wr_en      (act == ACT_LOAD),
        .wr_off     (off),
        .wr_data    (load_data_i),
        .rd_off     (scan_idx),
        .rd_data    (rd_data),
        .rd_marked  (rd_marked),
        .any_marked (any_marked)
    );

    psc_commit_seq #(
        .OFF_W     (OFF_W),
        .WR_CYCLES (WR_CYCLES)
    ) i_commit (
        .clk      (clk),
        .rst      (rst),
        .go       (act == ACT_COMMIT),
        .busy     (busy),
        .scan_on  (scan_on),
        .scan_idx (scan_idx),
        .done     (done)
    );

    assign busy_o      = busy;
    assign mem_we_o    = scan_on && rd_marked;
    assign mem_addr_o  = {page, scan_idx};
    assign mem_wdata_o = rd_data;
endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
    parameter int ADDR_W    = 14,
    parameter int OFF_W     = 6,
    parameter int WR_CYCLES = 500000,
    localparam int SPAN     = (WR_CYCLES < (1 << OFF_W)) ? (1 << OFF_W) : WR_CYCLES
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_i,
    input logic              abort_i,
    input logic              busy_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    int unsigned              run_q;
    logic                     seen_q;
    logic [ADDR_W-OFF_W-1:0]  pg_q;
    logic [OFF_W-1:0]         of_q;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) begin
            run_q  <= 0;
            seen_q <= 1'b0;
            pg_q   <= '0;
            of_q   <= '0;
        end else begin
            run_q <= run_q + 1;
            if (mem_we_o) begin
                seen_q <= 1'b1;
                pg_q   <= mem_addr_o[ADDR_W-1:OFF_W];
                of_q   <= mem_addr_o[OFF_W-1:0];
            end
        end
    end

    // R11
    we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i));

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_q < SPAN));

    // R8
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_i && !busy_o) |=> !busy_o);

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && seen_q) |-> (mem_addr_o[ADDR_W-1:OFF_W] == pg_q));

    // R5
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && seen_q) |-> (mem_addr_o[OFF_W-1:0] > of_q));
endmodule

bind page_stage_commit psc_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .WR_CYCLES (WR_CYCLES)
) i_psc_chk (
    .clk        (clk),
    .rst        (rst),
    .stop_i     (stop_i),
    .abort_i    (abort_i),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/test_page_stage_commit.sv
module test_page_stage_commit;
    localparam int W = 80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [13:0] start_addr_i = '0;
    logic        load_i = 1'b0;
    logic [7:0]  load_data_i = '0;
    logic        stop_i = 1'b0;
    logic        abort_i = 1'b0;
    logic        busy_o;
    logic        mem_we_o;
    logic [13:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;

    always #5 clk = ~clk;

    page_stage_commit #(.WR_CYCLES(W)) i_page_stage_commit (
        .clk (clk), .rst (rst),
        .start_i (start_i), .start_addr_i (start_addr_i),
        .load_i (load_i), .load_data_i (load_data_i),
        .stop_i (stop_i), .abort_i (abort_i),
        .busy_o (busy_o), .mem_we_o (mem_we_o),
        .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [21:0] exp_q[$];
    bit [7:0] sh_data [64];
    bit       sh_mark [64];
    bit [7:0] sh_page;
    bit [5:0] sh_off;
    bit       sh_act;
    int       exp_rises = 0;

    int   busy_cyc = 0;
    int   rise_cnt = 0;
    int   stray = 0;
    logic busy_d = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected writes, measures busy windows
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_o) begin
                if (!busy_d) rise_cnt++;
                if (mem_we_o) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R5", "unexpected write", int'(mem_addr_o), 0);
                    end else begin
                        logic [21:0] it;
                        it = exp_q.pop_front();
                        check(mem_addr_o == it[21:8], "R2", "write address",
                              int'(mem_addr_o), int'(it[21:8]));
                        check(mem_wdata_o == it[7:0], "R4", "write data",
                              int'(mem_wdata_o), int'(it[7:0]));
                        check(int'(mem_addr_o[5:0]) == busy_cyc, "R5", "write slot",
                              busy_cyc, int'(mem_addr_o[5:0]));
                    end
                end
                busy_cyc++;
            end else begin
                if (busy_d) check(busy_cyc == W, "R6", "busy length", busy_cyc, W);
                if (mem_we_o) stray++;
                busy_cyc = 0;
            end
            busy_d = busy_o;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic m_open(input logic [13:0] a);
        start_i = 1'b1; start_addr_i = a;
        sh_page = a[13:6]; sh_off = a[5:0]; sh_act = 1;
        for (int i = 0; i < 64; i++) sh_mark[i] = 0;
        tick();
        start_i = 1'b0;
    endtask

    task automatic m_load(input logic [7:0] d);
        load_i = 1'b1; load_data_i = d;
        if (sh_act) begin
            sh_data[sh_off] = d; sh_mark[sh_off] = 1; sh_off = sh_off + 1'b1;
        end
        tick();
        load_i = 1'b0;
    endtask

    task automatic m_stop();
        bit any;
        any = 0;
        stop_i = 1'b1;
        if (sh_act) begin
            for (int i = 0; i < 64; i++) begin
                if (sh_mark[i]) begin
                    any = 1;
                    exp_q.push_back({sh_page, 6'(i), sh_data[i]});
                end
                sh_mark[i] = 0;
            end
            if (any) exp_rises++;
            sh_act = 0;
        end
        tick();
        stop_i = 1'b0;
    endtask

    task automatic m_abort();
        abort_i = 1'b1;
        for (int i = 0; i < 64; i++) sh_mark[i] = 0;
        sh_act = 0;
        tick();
        abort_i = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (W + 6) tick();
        check(exp_q.size() == 0, req, "writes still owed", exp_q.size(), 0);
        check(rise_cnt == exp_rises, req, "busy rises", rise_cnt, exp_rises);
    endtask

    initial begin
        repeat (3) tick();
        check(busy_o == 1'b0 && mem_we_o == 1'b0, "R1", "in reset", {busy_o, mem_we_o}, 0);
        rst = 1'b0;
        tick();
        check(busy_o == 1'b0 && mem_we_o == 1'b0, "R1", "after reset", {busy_o, mem_we_o}, 0);

        // R2: single byte at page 0x48 offset 0x34
        m_open(14'h1234); m_load(8'hA5); m_stop(); drain("R2");

        // R3: wrap from offset 62 through 0
        m_open({8'h07, 6'd62});
        m_load(8'h11); m_load(8'h22); m_load(8'h33); m_load(8'h44);
        m_stop(); drain("R3");

        // R4: 70 loads from offset 0 overwrite 0..5
        m_open({8'h03, 6'd0});
        for (int i = 0; i < 70; i++) m_load(8'(i) ^ 8'h5A);
        m_stop(); drain("R4");

        // R8: abort then stop gives no cycle
        m_open(14'h0555); m_load(8'h99); m_abort(); m_stop(); drain("R8");

        // R7: earlier bytes never committed, via abort and via reopen
        m_open({8'h02, 6'd0});
        for (int i = 0; i < 4; i++) m_load(8'hC0 + 8'(i));
        m_abort();
        m_open({8'h02, 6'd10}); m_load(8'h3C); m_stop(); drain("R7");
        m_open({8'h09, 6'd20});
        for (int i = 0; i < 3; i++) m_load(8'hD0 + 8'(i));
        m_open({8'h09, 6'd40}); m_load(8'h7E); m_stop(); drain("R7");

        // R9: strobes while busy are ignored
        m_open(14'h0100); m_load(8'h77); m_stop();
        tick();
        start_i = 1'b1; start_addr_i = 14'h3FFF; tick(); start_i = 1'b0;
        load_i = 1'b1; load_data_i = 8'hEE; tick(); load_i = 1'b0;
        stop_i = 1'b1; tick(); stop_i = 1'b0;
        drain("R9");
        m_load(8'h12); m_stop(); drain("R9");
        m_open(14'h0200); m_load(8'h01); m_stop(); drain("R9");

        // R10: commit with nothing loaded
        m_open(14'h0333); m_stop(); drain("R10");

        check(stray == 0, "R11", "writes outside busy", stray, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule